// File: doc/BRIEF.md
# Maskable Status Flag Interrupt Controller

This block holds a 16-bit event status word and a 16-bit interrupt mask. Both sit behind a simple host register port: an address, a write strobe, a read strobe and a data path. Hardware sources inside the chip raise event flags. Each flag is set by a single-cycle pulse and stays set until the host reads the status word. Bit 0 is different. It is a handshake flag that follows a ready signal from the programming-register logic, and a status read never clears it.

Bit 15 of the status word is a summary interrupt bit. It is set when a flag changes state while that flag's mask bit is 1. The level of a flag does not set it. Bit 15 of the mask is the global enable. The active-low interrupt line is low only while both bit 15 of the status word and bit 15 of the mask are 1.

A status read does two things. It latches the status word for the host at the end of the command/address cycle, and in that same cycle it clears flags 14 to 1 and the summary bit. A write to the general reset address clears the mask, the event flags and the summary bit.

Top module: `stat_irq_ctrl`

## Requirements
- R1: After `rst_n` is released, `irq_n` is 1 and a status read returns 0x0000 while `prog_ready` is 0.
- R2: Status bit k (k = 1..14) is set on the clock edge where `evt[k-1]` is 1, and it stays set until the next status read or reset.
- R3: Status bit 0 equals the `prog_ready` value sampled on the previous clock edge, and a status read does not clear it.
- R4: Status bit 15 is set when flag k changes state and mask bit k is 1. A change on a flag whose mask bit is 0 does not set it.
- R5: `irq_n` is 0 exactly while status bit 15 and mask bit 15 are both 1.
- R6: Asserting `bus_rd` with address 0xC6 for one cycle loads `bus_rdata` at that edge with the status word as it was before the clear, and clears status bits 15 to 1.
- R7: An event pulse in the same cycle as a status read leaves its flag set. If that change is masked in, status bit 15 is set.
- R8: A write to address 0xCE loads the mask from `bus_wdata` and leaves the flags unchanged. If status bit 15 is already 1, writing mask bit 15 as 1 drives `irq_n` low after that clock edge.
- R9: A write to address 0x01 clears the mask, status bits 15 to 1, and `irq_n` returns to 1.
- R10: Writes to address 0xCF and reads of any address other than 0xC6 have no effect on the mask or the flags.
- R11: An event pulse on a flag that is already set is not a change of state and does not set status bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Host register address |
| bus_wr | input | 1 | Host write strobe, one cycle |
| bus_rd | input | 1 | Host read strobe, marks end of command/address phase |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Status word latched by the last status read |
| evt | input | 14 | Event pulses; bit j sets status bit j+1 |
| prog_ready | input | 1 | Ready level from programming-register logic, drives bit 0 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Faults in this block are visible at the ports. A lost or stuck flag shows up in the value returned by the next status read. A faulty change detector shows as `irq_n` falling, or failing to fall, one edge after the event pulse. A clear that acts on the wrong bits appears at the read that follows: either bit 0 drops out, or a stale flag survives. The bench therefore brackets each stimulus with back-to-back status reads and `irq_n` samples. This pins every error down to the cycle in which it appeared.

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl #(
  parameter int          AW          = 8,
  parameter logic [7:0]  ADDR_RESET  = 8'h01,
  parameter logic [7:0]  ADDR_STATUS = 8'hC6,
  parameter logic [7:0]  ADDR_MASK   = 8'hCE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  input  logic [13:0]   evt,
  input  logic          prog_ready,
  output logic          irq_n
);

  logic [14:1] flags_q;
  logic        flag0_q;
  logic        irq_q;
  logic [15:0] mask_q;
  logic [15:0] rdata_q;

  wire rd_stat = bus_rd && (bus_addr == ADDR_STATUS);
  wire wr_mask = bus_wr && (bus_addr == ADDR_MASK);
  wire wr_rst  = bus_wr && (bus_addr == ADDR_RESET);
  wire clr     = rd_stat || wr_rst;

  // only rising event edges and bit-0 toggles count as changes; clears do not
  wire [14:0] chg     = {evt & ~flags_q, prog_ready ^ flag0_q};
  wire        irq_set = |(chg & mask_q[14:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      flag0_q <= 1'b0;
      irq_q   <= 1'b0;
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      flag0_q <= prog_ready;
      flags_q <= (clr ? '0 : flags_q) | evt;
      irq_q   <= irq_set | (irq_q & ~clr);
      if (wr_rst)       mask_q <= '0;
      else if (wr_mask) mask_q <= bus_wdata;
      if (rd_stat)      rdata_q <= {irq_q, flags_q, flag0_q};
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_n     = ~(irq_q & mask_q[15]);

endmodule

// File: rtl/stat_irq_ctrl_chk.sv
module stat_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [13:0] evt,
  input logic        prog_ready,
  input logic        irq_n,
  input logic [14:1] flags,
  input logic        flag0,
  input logic        irq,
  input logic [15:0] mask
);

  wire clr_cyc = (bus_rd && bus_addr == 8'hC6) || (bus_wr && bus_addr == 8'h01);

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_cyc |=> ((flags & $past(flags)) == $past(flags)));

  p_bit0_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (flag0 == $past(prog_ready)));

  p_unmasked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && mask[14:0] == '0) |=> !irq);

  p_irq_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> (irq && mask[15]));

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 8'hC6 && evt == '0 && mask[14:0] == '0) |=> (flags == '0 && !irq));

  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cyc && evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

  p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h01) |=> (mask == '0 && irq_n));

  p_test_addr_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'hCF) |=> $stable(mask));

endmodule

bind stat_irq_ctrl stat_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .evt(evt), .prog_ready(prog_ready), .irq_n(irq_n),
  .flags(flags_q), .flag0(flag0_q), .irq(irq_q), .mask(mask_q)
);

// File: tb/tb_stat_irq_ctrl.sv
`timescale 1ns/1ps
module tb_stat_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [13:0] evt = '0;
  logic        prog_ready = 1'b0;
  logic        irq_n;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  stat_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt(evt), .prog_ready(prog_ready),
    .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic pulse(input int bitpos);
    @(negedge clk);
    evt = 14'b1 << (bitpos - 1);
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 irq_n after reset", {15'b0, irq_n}, 16'h0001);
    rd(8'hC6, v);
    chk("R1 status after reset", v, 16'h0000);
  endtask

  task automatic t_sticky();
    logic [15:0] v;
    wr(8'hCE, 16'h8002);
    pulse(1);
    idle(3);
    chk("R5 irq_n low on masked change", {15'b0, irq_n}, 16'h0000);
    rd(8'hC6, v);
    chk("R2 R6 sticky flag read", v, 16'h8002);
    chk("R6 irq_n released by read", {15'b0, irq_n}, 16'h0001);
    rd(8'hC6, v);
    chk("R6 flags cleared", v, 16'h0000);
  endtask

  task automatic t_unmasked();
    logic [15:0] v;
    pulse(5);
    idle(2);
    chk("R4 unmasked change no irq", {15'b0, irq_n}, 16'h0001);
    rd(8'hC6, v);
    chk("R4 unmasked flag set, IRQ bit clear", v, 16'h0020);
  endtask

  task automatic t_bit0();
    logic [15:0] v;
    wr(8'hCE, 16'h8001);
    @(negedge clk); prog_ready = 1'b1;
    idle(2);
    chk("R3 R4 bit0 change raises irq", {15'b0, irq_n}, 16'h0000);
    rd(8'hC6, v);
    chk("R3 bit0 read", v, 16'h8001);
    rd(8'hC6, v);
    chk("R3 bit0 survives read", v, 16'h0001);
    @(negedge clk); prog_ready = 1'b0;
    idle(2);
    rd(8'hC6, v);
    chk("R3 bit0 fall sets IRQ bit", v, 16'h8000);
    rd(8'hC6, v);
    chk("R3 cleared after fall", v, 16'h0000);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    wr(8'hCE, 16'h8008);
    @(negedge clk);
    bus_addr = 8'hC6; bus_rd = 1'b1; evt = 14'b1 << 2;
    @(negedge clk);
    bus_rd = 1'b0; evt = '0;
    chk("R6 pre-clear value", bus_rdata, 16'h0000);
    chk("R7 event wins over clear", {15'b0, irq_n}, 16'h0000);
    rd(8'hC6, v);
    chk("R7 flag kept", v, 16'h8008);
  endtask

  task automatic t_already_set();
    logic [15:0] v;
    wr(8'hCE, 16'h0000);
    pulse(2);
    wr(8'hCE, 16'h8004);
    idle(1);
    chk("R8 mask write keeps irq off", {15'b0, irq_n}, 16'h0001);
    pulse(2);
    idle(2);
    chk("R11 repeat pulse no irq", {15'b0, irq_n}, 16'h0001);
    rd(8'hC6, v);
    chk("R8 R11 flag kept, no IRQ bit", v, 16'h0004);
  endtask

  task automatic t_mask_late();
    logic [15:0] v;
    wr(8'hCE, 16'h0010);
    pulse(4);
    idle(1);
    chk("R5 global enable off", {15'b0, irq_n}, 16'h0001);
    wr(8'hCE, 16'h8010);
    chk("R8 late enable asserts", {15'b0, irq_n}, 16'h0000);
    rd(8'hC6, v);
    chk("R8 status after late enable", v, 16'h8010);
  endtask

  task automatic t_softrst();
    logic [15:0] v;
    wr(8'hCE, 16'h8040);
    pulse(6);
    idle(1);
    chk("R5 irq before soft reset", {15'b0, irq_n}, 16'h0000);
    wr(8'h01, 16'h0000);
    chk("R9 irq_n released", {15'b0, irq_n}, 16'h0001);
    pulse(6);
    idle(2);
    chk("R9 mask cleared", {15'b0, irq_n}, 16'h0001);
    rd(8'hC6, v);
    chk("R9 flags cleared then reset", v, 16'h0040);
  endtask

  task automatic t_ignored();
    logic [15:0] v;
    wr(8'hCE, 16'h8080);
    wr(8'hCF, 16'h0000);
    pulse(7);
    idle(1);
    chk("R10 test address write ignored", {15'b0, irq_n}, 16'h0000);
    rd(8'hC5, v);
    chk("R10 other read leaves irq", {15'b0, irq_n}, 16'h0000);
    rd(8'hC6, v);
    chk("R10 flags kept by other read", v, 16'h8080);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_sticky();
    t_unmasked();
    t_bit0();
    t_collide();
    t_already_set();
    t_mask_late();
    t_softrst();
    t_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule